// File: doc/BRIEF.md
# Register Result Status Rename Table

This block keeps, for every architectural floating-point register, a record of which reservation station tag will deliver that register's next value. An entry that holds no tag is blank, and the register file then holds the current value. The dispatch logic uses the table in two ways. It looks up each source register, and the table answers either "ready, here is the value" or "wait for this tag". It also renames the destination register to the tag of the station that receives the instruction.

The table also watches the single result bus. When a result is broadcast, each register whose entry still names that tag takes the value into the register file, and its entry goes blank. A register that has since been renamed to a younger producer does not match, so the stale result is dropped and the younger one stays pending. A source whose producer is on the bus in the lookup cycle is returned ready with the bus value.

Each entry is a two-state machine. The states are `ENT_BLANK` (no pending writer, tag field zero) and `ENT_PEND` (waiting on the stored tag). The transitions are:
- T_RENAME: from `ENT_BLANK` to `ENT_PEND` on an issue to this register.
- T_RERENAME: from `ENT_PEND` to `ENT_PEND` with a new tag on an issue. This transition wins over a matching broadcast in the same cycle.
- T_RETIRE: from `ENT_PEND` to `ENT_BLANK` on a matching broadcast.
- T_HOLD: any other cycle, where the entry keeps its state.

Top module: `reg_rename_table`

## Requirements
- R1: After reset every entry is blank and every register reads as ready with value zero and tag output zero.
- R2: A source whose entry is blank is returned with ready high, tag output zero and the value held in the register file.
- R3: A source whose entry holds a tag, with no matching broadcast in that cycle, is returned with ready low and that tag on its tag output.
- R4: An issue with a nonzero tag overwrites the destination entry with that tag from the next cycle, replacing any older tag.
- R5: A valid broadcast whose tag equals a register's pending tag writes the bus data into that register and leaves the entry blank from the next cycle.
- R6: A valid broadcast whose tag differs from a register's pending tag leaves that register's value and entry unchanged, so a superseded result is dropped.
- R7: When an issue renames a register in the same cycle that a matching broadcast would retire it, the entry holds the new tag afterwards.
- R8: A source whose pending tag equals the tag of a valid broadcast in the same cycle is returned ready, with the bus data as its value.
- R9: Tag value 0 means blank. An issue carrying tag 0 leaves the table unchanged, and a broadcast carrying tag 0 writes nothing.
- R10: Source lookups reflect the table as it was before any issue in the same cycle, so a source naming the register being renamed sees its prior state.
- R11: With the bus-valid input low, no register or entry changes because of the bus tag or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue renames a destination this cycle |
| iss_dst | input | IDX_W (5) | Destination register index |
| iss_tag | input | TAG_W (4) | Station tag of the issuing instruction; 0 is ignored |
| bus_valid | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | TAG_W (4) | Tag of the broadcasting station |
| bus_data | input | DATA_W (32) | Broadcast result value |
| src_idx | input | NUM_SRC*IDX_W (10) | Source register indices; source p in bits [p*IDX_W +: IDX_W] |
| src_rdy | output | NUM_SRC (2) | Per source: value available now |
| src_tag | output | NUM_SRC*TAG_W (8) | Per source: producer tag to wait on, zero when ready |
| src_val | output | NUM_SRC*DATA_W (64) | Per source: operand value when ready |

## Verification
The assertions assume that an issuing instruction presents a nonzero tag whenever it means to rename. They also assume that the bus tag is compared only while bus-valid is high, and that reset is held for at least one clock edge before the first issue. The stimulus renames registers only through the issue port. It applies reset for several cycles before any traffic. In the directed part it keeps outstanding tags unique. In the mixed part tags may be reused, and the bench model retires every matching entry, in the same way the stated rule does.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    // Per-register entry state: blank (register file is current) or pending on a tag.
    typedef enum logic {
        ENT_BLANK = 1'b0,
        ENT_PEND  = 1'b1
    } ent_state_t;

endpackage

// File: rtl/rrt_entry.sv
module rrt_entry
    import rrt_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_hit,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic             bus_valid,
    input  logic [TAG_W-1:0] bus_tag,
    output logic             pend,
    output logic [TAG_W-1:0] prod_tag,
    output logic             wr_hit
);

    ent_state_t       state_q, state_d;
    logic [TAG_W-1:0] tag_q, tag_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_BLANK;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
        end
    end

    // Next state: T_RENAME, T_RERENAME, T_RETIRE, T_HOLD
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        unique case (state_q)
            ENT_BLANK: begin
                if (iss_hit) begin
                    state_d = ENT_PEND;
                    tag_d   = iss_tag;
                end
            end
            ENT_PEND: begin
                if (iss_hit) begin
                    state_d = ENT_PEND;
                    tag_d   = iss_tag;
                end else if (wr_hit) begin
                    state_d = ENT_BLANK;
                    tag_d   = '0;
                end
            end
            default: begin
                state_d = ENT_BLANK;
                tag_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        pend     = (state_q == ENT_PEND);
        prod_tag = tag_q;
        wr_hit   = (state_q == ENT_PEND) && bus_valid &&
                   (bus_tag != '0) && (bus_tag == tag_q);
    end

    p_rename_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_hit |=> (pend && prod_tag == $past(iss_tag)));

    p_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !iss_hit) |=> !pend);

    p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_hit && !wr_hit) |=> ($stable(prod_tag) && $stable(pend)));

    p_blank_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (prod_tag != '0));

endmodule

// File: rtl/rrt_regfile.sv
module rrt_regfile #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REGS-1:0]       wr_en,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [NUM_SRC*IDX_W-1:0]  rd_idx,
    output logic [NUM_SRC*DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[r] <= '0;
            else if (wr_en[r])
                mem[r] <= wr_data;
        end

        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[r] |=> $stable(mem[r]));
    end

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_rd
        assign rd_data[p*DATA_W +: DATA_W] = mem[rd_idx[p*IDX_W +: IDX_W]];
    end

endmodule

// File: rtl/rrt_lookup.sv
module rrt_lookup #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_REGS-1:0]       pend_vec,
    input  logic [NUM_REGS*TAG_W-1:0] tag_vec,
    input  logic [DATA_W-1:0]         rf_data,
    input  logic                      bus_valid,
    input  logic [TAG_W-1:0]          bus_tag,
    input  logic [DATA_W-1:0]         bus_data,
    output logic                      rdy,
    output logic [TAG_W-1:0]          tag,
    output logic [DATA_W-1:0]         val
);

    logic             sel_pend;
    logic [TAG_W-1:0] sel_tag;
    logic             bypass;

    always_comb begin
        sel_pend = pend_vec[idx];
        sel_tag  = tag_vec[idx*TAG_W +: TAG_W];
        bypass   = sel_pend && bus_valid && (bus_tag != '0) && (bus_tag == sel_tag);
        rdy      = !sel_pend || bypass;
        tag      = (sel_pend && !bypass) ? sel_tag : '0;
        if (bypass)
            val = bus_data;
        else if (sel_pend)
            val = '0;
        else
            val = rf_data;
    end

    p_wait_has_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (tag != '0));

    p_blank_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[idx] |-> (rdy && val == rf_data));

endmodule

// File: rtl/reg_rename_table.sv
module reg_rename_table #(
    parameter int NUM_REGS = 32,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = 2,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      iss_valid,
    input  logic [IDX_W-1:0]          iss_dst,
    input  logic [TAG_W-1:0]          iss_tag,
    input  logic                      bus_valid,
    input  logic [TAG_W-1:0]          bus_tag,
    input  logic [DATA_W-1:0]         bus_data,
    input  logic [NUM_SRC*IDX_W-1:0]  src_idx,
    output logic [NUM_SRC-1:0]        src_rdy,
    output logic [NUM_SRC*TAG_W-1:0]  src_tag,
    output logic [NUM_SRC*DATA_W-1:0] src_val
);

    logic [NUM_REGS-1:0]       pend_vec;
    logic [NUM_REGS*TAG_W-1:0] tag_vec;
    logic [NUM_REGS-1:0]       wr_en;
    logic [NUM_SRC*DATA_W-1:0] rf_rd;
    logic                      iss_live;

    assign iss_live = iss_valid && (iss_tag != '0);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
        logic hit;
        assign hit = iss_live && (iss_dst == IDX_W'(r));
        rrt_entry #(.TAG_W(TAG_W)) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .iss_hit  (hit),
            .iss_tag  (iss_tag),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .pend     (pend_vec[r]),
            .prod_tag (tag_vec[r*TAG_W +: TAG_W]),
            .wr_hit   (wr_en[r])
        );
    end

    rrt_regfile #(
        .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(bus_data),
        .rd_idx (src_idx),
        .rd_data(rf_rd)
    );

    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        rrt_lookup #(
            .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
        ) u_lk (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (src_idx[p*IDX_W +: IDX_W]),
            .pend_vec (pend_vec),
            .tag_vec  (tag_vec),
            .rf_data  (rf_rd[p*DATA_W +: DATA_W]),
            .bus_valid(bus_valid),
            .bus_tag  (bus_tag),
            .bus_data (bus_data),
            .rdy      (src_rdy[p]),
            .tag      (src_tag[p*TAG_W +: TAG_W]),
            .val      (src_val[p*DATA_W +: DATA_W])
        );
    end

    p_zero_tag_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_tag == '0) |-> (wr_en == '0));

    p_idle_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (wr_en == '0));

    p_at_most_one_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> bus_valid);

endmodule

// File: tb/sim_reg_rename_table.sv
module sim_reg_rename_table;

    localparam int CLK_P = 10;
    localparam int NR    = 32;
    localparam int TW    = 4;
    localparam int DW    = 32;
    localparam int NS    = 2;
    localparam int IW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [IW-1:0] iss_dst = '0;
    logic [TW-1:0] iss_tag = '0;
    logic          bus_valid = 1'b0;
    logic [TW-1:0] bus_tag = '0;
    logic [DW-1:0] bus_data = '0;
    logic [NS*IW-1:0] src_idx = '0;
    logic [NS-1:0]    src_rdy;
    logic [NS*TW-1:0] src_tag;
    logic [NS*DW-1:0] src_val;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    reg_rename_table u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .src_idx(src_idx), .src_rdy(src_rdy), .src_tag(src_tag), .src_val(src_val)
    );

    typedef struct packed {
        logic          rdy;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];

    int            mtag [NR];
    logic [DW-1:0] mval [NR];

    // Driver: applies one cycle of stimulus, pushes expected lookups, updates the model.
    task automatic step(input bit iv, input int dst, input int itag,
                        input bit bv, input int btag, input logic [DW-1:0] bdata,
                        input int s0, input int s1, input string req);
        int srcs[2];
        srcs[0] = s0;
        srcs[1] = s1;
        @(negedge clk);
        iss_valid = iv;
        iss_dst   = IW'(dst);
        iss_tag   = TW'(itag);
        bus_valid = bv;
        bus_tag   = TW'(btag);
        bus_data  = bdata;
        src_idx   = {IW'(s1), IW'(s0)};
        for (int p = 0; p < NS; p++) begin
            exp_t e;
            bit pending, byp;
            pending = (mtag[srcs[p]] != 0);
            byp = pending && bv && (btag != 0) && (btag == mtag[srcs[p]]);
            e.rdy = !pending || byp;
            e.tag = (pending && !byp) ? TW'(mtag[srcs[p]]) : '0;
            e.val = byp ? bdata : (pending ? '0 : mval[srcs[p]]);
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        @(posedge clk);
        #1;
        for (int r = 0; r < NR; r++) begin
            if (bv && btag != 0 && mtag[r] == btag) begin
                mval[r] = bdata;
                mtag[r] = 0;
            end
        end
        if (iv && itag != 0) mtag[dst] = itag;
    endtask

    task automatic idle_read(input int s0, input int s1, input string req);
        step(0, 0, 0, 0, 0, '0, s0, s1, req);
    endtask

    // Monitor: pops expectations and compares them with the lookup outputs.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            for (int p = 0; p < NS; p++) begin
                if (exp_q.size() > 0) begin
                    exp_t  e;
                    string rq;
                    logic          a_rdy;
                    logic [TW-1:0] a_tag;
                    logic [DW-1:0] a_val;
                    e  = exp_q.pop_front();
                    rq = req_q.pop_front();
                    a_rdy = src_rdy[p];
                    a_tag = src_tag[p*TW +: TW];
                    a_val = src_val[p*DW +: DW];
                    total++;
                    if (a_rdy !== e.rdy || a_tag !== e.tag ||
                        (e.rdy && a_val !== e.val)) begin
                        bad++;
                        $display("FAIL %s src%0d: got rdy=%0b tag=%0d val=%h exp rdy=%0b tag=%0d val=%h",
                                 rq, p, a_rdy, a_tag, a_val, e.rdy, e.tag, e.val);
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, got hang exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            mtag[r] = 0;
            mval[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle_read(0, 31, "R1");
        idle_read(7, 19, "R1");

        // R10: rename r2 while reading r2 in the same cycle
        step(1, 2, 3, 0, 0, '0, 2, 5, "R10");
        // R3: r2 waits on tag 3
        idle_read(2, 5, "R3");
        // R8: tag 3 on the bus bypasses to r2; R2 for blank r5
        step(0, 0, 0, 1, 3, 32'h0000_AAAA, 2, 5, "R8");
        // R5: r2 now holds the value, entry blank
        idle_read(2, 2, "R5");
        // R2: blank register returns its register file value
        idle_read(5, 2, "R2");

        // R4: rename r4 twice, the younger tag replaces the older
        step(1, 4, 5, 0, 0, '0, 4, 0, "R4");
        step(1, 4, 6, 0, 0, '0, 4, 0, "R4");
        idle_read(4, 4, "R4");
        // R6: the superseded tag 5 is dropped
        step(0, 0, 0, 1, 5, 32'h1111_1111, 4, 2, "R6");
        idle_read(4, 2, "R6");

        // R7: matching broadcast and rename of the same register together
        step(1, 4, 7, 1, 6, 32'h2222_2222, 4, 4, "R7");
        idle_read(4, 4, "R7");
        step(0, 0, 0, 1, 7, 32'h3333_3333, 4, 4, "R5");
        idle_read(4, 2, "R5");

        // R9: issue with tag 0 and broadcast with tag 0 change nothing
        step(1, 6, 0, 0, 0, '0, 6, 4, "R9");
        idle_read(6, 4, "R9");
        step(0, 0, 0, 1, 0, 32'hDEAD_BEEF, 6, 4, "R9");
        idle_read(6, 4, "R9");

        // R11: a matching tag with bus-valid low is ignored
        step(1, 8, 9, 0, 0, '0, 8, 0, "R11");
        step(0, 0, 0, 0, 9, 32'h5555_5555, 8, 0, "R11");
        idle_read(8, 0, "R11");
        step(0, 0, 0, 1, 9, 32'h6666_6666, 8, 0, "R8");
        idle_read(8, 0, "R5");

        // R5 and R6: several pending registers, only the match retires
        step(1, 10, 11, 0, 0, '0, 10, 11, "R4");
        step(1, 11, 12, 0, 0, '0, 10, 11, "R4");
        step(0, 0, 0, 1, 12, 32'h0BAD_F00D, 10, 11, "R6");
        idle_read(10, 11, "R5");

        // Mixed traffic with random renames and broadcasts
        for (int k = 0; k < 300; k++) begin
            int d, t, b;
            d = $urandom_range(0, NR - 1);
            t = $urandom_range(0, 15);
            b = $urandom_range(0, 15);
            step($urandom_range(0, 1) == 1, d, t, $urandom_range(0, 1) == 1, b,
                 $urandom(), $urandom_range(0, NR - 1), d, "R5");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule